// File: doc/BRIEF.md
# Gated-Strobe Parallel-to-Serial Shifter

This block turns a parallel word into a serial bit stream, most significant stage first. A level-sensitive, active-low load copies the parallel word into every stage. Once load is released, each rising edge of a shift strobe moves the word one stage toward the output. The shift strobe is the OR of an external shift clock and an active-low enable. The last stage drives two outputs: a true output and its inverse. A serial input feeds stage 0, so several of these blocks can be chained.

The block runs entirely in a fast system-clock domain. The external shift clock and enable are sampled as plain data on that clock. A shift is produced when their OR is seen low in one system cycle and high in the next. While load is held low, the output follows the top parallel bit combinationally. A strobe edge that arrives in the same system cycle as the release of load is discarded. This gives the load a recovery cycle before the first shift.

Top module: `piso_gated_shifter`

## Requirements
- R1: A synchronous active-high reset clears every stage to 0, so `q_out` is 0 and `q_out_n` is 1. The strobe history is preset high, so a strobe that is already high when reset is released causes no shift.
- R2: While `load_n` is 0, every stage n takes `par_in[n]` on each system clock. This holds whatever the values of `sclk`, `sen_n` and `ser_in`.
- R3: While `load_n` is 0, `q_out` equals `par_in[WIDTH-1]` combinationally, with no clock edge needed.
- R4: With `load_n` at 1, a rising edge of the strobe `sclk | sen_n` causes a shift. The edge is detected as 0 in one sampled cycle and 1 in the next. On a shift, `ser_in` enters stage 0 and stage n moves to stage n+1. After a load, `q_out` therefore shows `par_in[WIDTH-1]`, then the lower bits in descending order. After WIDTH shifts it shows the first serial bit.
- R5: While `sen_n` stays at 1, toggling `sclk` leaves all stages unchanged.
- R6: Two enable changes cause no shift: `sen_n` falling while `sclk` is 0, and `sen_n` changing while `sclk` is 1.
- R7: `q_out_n` is always the logical inverse of `q_out`.
- R8: A strobe rising edge seen in the same system cycle that `load_n` goes from 0 to 1 causes no shift.
- R9: A strobe held high over many system cycles causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load, active low, level-sensitive |
| sclk | input | 1 | External shift clock, sampled as data |
| sen_n | input | 1 | Shift enable, active low, ORed with `sclk` |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel word; bit n goes to stage n |
| q_out | output | 1 | Last stage, or `par_in[WIDTH-1]` while loading |
| q_out_n | output | 1 | Inverse of `q_out` |

## Verification
The assertions assume that `sclk` and `sen_n` are already settled data in the system-clock domain. They also assume that a strobe edge is meant as a shift only when load has been high for a full cycle. The stimulus changes inputs only at the falling system edge. It raises `sen_n` only while `sclk` is high, because a rising enable while the shift clock is low is itself a strobe edge. Before releasing load, the stimulus brings the strobe low for at least one cycle, unless it is testing the discarded edge of R8 on purpose.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } stage_op_e;

    typedef struct packed {
        logic strobe_prev;
        logic load_prev;
    } strobe_state_t;

endpackage

// File: rtl/strobe_edge_detect.sv
`timescale 1ns/1ps
module strobe_edge_detect
    import piso_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sen_n,
    input  logic load_n,
    output logic shift_pulse
);

    strobe_state_t st_d, st_q;
    logic          strobe_now;
    logic          strobe_rise;

    always_comb begin
        strobe_now     = sclk | sen_n;
        strobe_rise    = strobe_now & ~st_q.strobe_prev;
        // a rise is honoured only if load was already high last cycle
        shift_pulse    = strobe_rise & load_n & st_q.load_prev;
        st_d.strobe_prev = strobe_now;
        st_d.load_prev   = load_n;
        if (rst) begin
            st_d.strobe_prev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R9: a strobe edge yields one shift, never two in a row
    a_r9_one_per_edge: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> !shift_pulse);

endmodule

// File: rtl/shift_stages.sv
`timescale 1ns/1ps
module shift_stages
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  stage_op_e        op,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stage_o
);

    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] stage_d, stage_q;
    logic [WIDTH-1:0] shift_src;

    assign shift_src[0] = ser_in;
    for (genvar i = 1; i < WIDTH; i++) begin : g_chain
        assign shift_src[i] = stage_q[i-1];
    end

    always_comb begin
        case (op)
            OP_LOAD:  stage_d = par_in;
            OP_SHIFT: stage_d = shift_src;
            default:  stage_d = stage_q;
        endcase
        if (rst) begin
            stage_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        stage_q <= stage_d;
    end

    assign stage_o = stage_q;

    // R1: reset clears all stages
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (stage_q == '0));

    // R2: load copies the parallel word
    a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> (stage_q == $past(par_in)));

    // R4: shift moves each stage up by one and feeds stage 0 from ser_in
    a_r4_shift_chain: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> ((stage_q[LAST:1] == $past(stage_q[LAST-1:0]))
                              && (stage_q[0] == $past(ser_in))));

endmodule

// File: rtl/piso_gated_shifter.sv
`timescale 1ns/1ps
module piso_gated_shifter
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic             sclk,
    input  logic             sen_n,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             q_out,
    output logic             q_out_n
);

    localparam int TAIL = WIDTH - 1;

    logic             shift_pulse;
    stage_op_e        op;
    logic [WIDTH-1:0] stages;
    logic             tail;

    strobe_edge_detect u_edge (
        .clk         (clk),
        .rst         (rst),
        .sclk        (sclk),
        .sen_n       (sen_n),
        .load_n      (load_n),
        .shift_pulse (shift_pulse)
    );

    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (shift_pulse) begin
            op = OP_SHIFT;
        end else begin
            op = OP_HOLD;
        end
    end

    shift_stages #(.WIDTH(WIDTH)) u_stages (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .par_in  (par_in),
        .ser_in  (ser_in),
        .stage_o (stages)
    );

    // load is transparent to the output while held low
    always_comb begin
        tail    = load_n ? stages[TAIL] : par_in[TAIL];
        q_out   = tail;
        q_out_n = ~tail;
    end

    // R5: enable held high freezes the stages
    a_r5_enable_inhibit: assert property (@(posedge clk) disable iff (rst)
        (load_n && sen_n && $past(sen_n)) |=> $stable(stages));

    // R8: strobe edge in the load-release cycle is discarded
    a_r8_release_guard: assert property (@(posedge clk) disable iff (rst)
        (load_n && !$past(load_n)) |=> $stable(stages));

    // R3: while loading, the output tracks the top parallel bit
    a_r3_load_transparent: assert property (@(posedge clk) disable iff (rst)
        !load_n |-> (q_out == par_in[TAIL]));

endmodule

// File: tb/sim_piso_gated_shifter.sv
`timescale 1ns/1ps
module sim_piso_gated_shifter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sen_n = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] par_in = 8'h00;
    logic       q_out;
    logic       q_out_n;

    int         checks = 0;
    int         errors = 0;
    logic       done = 1'b0;
    logic [7:0] model = 8'h00;

    // {serial bit, parallel word}
    localparam logic [8:0] VECS [6] = '{
        9'h1A5, 9'h05A, 9'h100, 9'h0FF, 9'h181, 9'h03C
    };

    always #2 clk = ~clk;

    piso_gated_shifter #(.WIDTH(8)) u0 (
        .clk     (clk),
        .rst     (rst),
        .load_n  (load_n),
        .sclk    (sclk),
        .sen_n   (sen_n),
        .ser_in  (ser_in),
        .par_in  (par_in),
        .q_out   (q_out),
        .q_out_n (q_out_n)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // every check also covers R7 (complement pair)
    task automatic check_out(input logic exp, input string tag);
        checks++;
        if (q_out !== exp || q_out_n !== ~exp) begin
            errors++;
            $display("FAIL %s (R7 pair): q_out=%b q_out_n=%b expected %b/%b",
                     tag, q_out, q_out_n, exp, ~exp);
        end
    endtask

    task automatic pulse();
        sclk = 1'b1;
        tick();
        model = {model[6:0], ser_in};
        sclk = 1'b0;
        tick();
    endtask

    task automatic load_pat(input logic [7:0] pat);
        load_n = 1'b0;
        par_in = pat;
        sclk   = 1'b1;
        sen_n  = 1'b1;
        ser_in = ~ser_in;
        tick();
        sclk  = 1'b0;
        sen_n = 1'b0;
        tick();
        model = pat;
        check_out(pat[7], "R2 load");
        par_in = ~pat;
        #1;
        check_out(~pat[7], "R3 transparent");
        par_in = pat;
        tick();
        load_n = 1'b1;
        tick();
        check_out(pat[7], "R2 after release");
    endtask

    initial begin
        // R1: reset with strobe already high
        rst = 1'b1; sclk = 1'b1; sen_n = 1'b0; ser_in = 1'b1; load_n = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        model = 8'h00;
        check_out(1'b0, "R1 reset state");
        ser_in = 1'b0;
        sclk = 1'b0;
        tick();
        repeat (7) pulse();
        check_out(1'b0, "R1 no spurious shift");

        // R4: table walk
        for (int v = 0; v < 6; v++) begin
            logic [7:0] pat;
            logic       sbit;
            pat  = VECS[v][7:0];
            sbit = VECS[v][8];
            load_pat(pat);
            ser_in = sbit;
            for (int k = 1; k <= 8; k++) begin
                pulse();
                check_out((k < 8) ? pat[7-k] : sbit, (k < 8) ? "R4 data" : "R4 serial");
            end
        end

        // R5 / R6
        load_pat(8'hAA);
        ser_in = 1'b0;
        sclk = 1'b1;
        tick();
        model = {model[6:0], ser_in};
        check_out(model[7], "R4 single shift");
        sen_n = 1'b1; tick();
        sclk = 1'b0;  tick();
        sclk = 1'b1;  tick();
        sclk = 1'b0;  tick();
        sclk = 1'b1;  tick();
        check_out(model[7], "R5 inhibit");
        sen_n = 1'b0; tick();
        sen_n = 1'b1; tick();
        sen_n = 1'b0; tick();
        check_out(model[7], "R6 enable moves with clock high");
        sen_n = 1'b1; tick();
        sclk  = 1'b0; tick();
        sen_n = 1'b0; tick();
        check_out(model[7], "R6 enable falls with clock low");
        pulse();
        check_out(model[7], "R5 shifting resumes");

        // R9
        load_pat(8'hAA);
        sclk = 1'b1;
        repeat (5) tick();
        model = {model[6:0], ser_in};
        check_out(model[7], "R9 held strobe");
        sclk = 1'b0;
        tick();

        // R8
        load_n = 1'b0; par_in = 8'h80; sclk = 1'b0; sen_n = 1'b0;
        tick(); tick();
        model = 8'h80;
        load_n = 1'b1; sclk = 1'b1;
        tick(); tick();
        check_out(1'b1, "R8 release edge ignored");
        sclk = 1'b0;
        tick();
        pulse();
        check_out(model[7], "R8 next edge shifts");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule